// File: doc/BRIEF.md
# SDRAM Command Decode Front End

This block is the command-input side of a four-bank synchronous DRAM. On every rising clock edge it samples chip select, the three strobes (row, column, write), the bank address, the address bus and the clock enable. It turns each legal command into a registered command report, keeps an open/idle flag for each bank, and flags commands that break the bank protocol. It holds a small mode state (CAS latency and a fast output-enable option) written by the two mode-register commands.

The block also runs the clock-enable state machine. It has four states. `PS_RUN` is normal operation. `PS_SUSPEND` is clock suspend, in which all pipelines freeze. `PS_PWRDN` is power-down. `PS_SELFREF` is self-refresh. The transitions are:
- RUN→SUSPEND when CKE is sampled low while any bank is open.
- RUN→SELFREF when CKE is sampled low with every bank idle and a refresh command at the same edge.
- RUN→PWRDN when CKE is sampled low with every bank idle and no refresh command.
- Any other state→RUN when CKE is sampled high again.

Finally, the block produces the byte-lane write enables and the read drive enables from the data-mask inputs, with the timing a DRAM data path needs. A memory model or controller bench uses it to know, cycle by cycle, which command executed, on which bank and row or column, and when read data may be driven.

Top module: `sdram_cmd_front`

## Requirements
- R1: Command encoding. With chip select low, the strobe triple {ras_n,cas_n,we_n} is decoded as follows: 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode write. Any other triple is a no-op. Each accepted command appears on `cmd_code` in the cycle after the sampling edge. The codes are: 0 no-op, 1 activate, 2 read, 3 write, 4 precharge, 5 refresh, 6 mode, 7 extended mode. In that same cycle, `cmd_bank`, `cmd_row` (the whole address) and `cmd_ap` (address bit 10) report the command's bank and address.
- R2: While chip select is high, the command is ignored. `cmd_code` reports 0 and no bank changes state, but a read already issued still completes.
- R3: An activate to an idle bank opens that bank. An activate to an open bank is rejected.
- R4: A read or write to an open bank is accepted. In x16 mode, `cmd_col` reports address bits 7:0 with bit 8 zero. A read or write to an idle bank is rejected.
- R5: A read or write with address bit 10 high closes its bank; the bank reads idle from the next cycle.
- R6: A precharge with address bit 10 low closes only the addressed bank. With bit 10 high, it closes all banks.
- R7: A mode write uses bank address 0 or 1:
  - With bank address 0, it loads the CAS latency from address bits 5:4. A value of 0 leaves the latency unchanged.
  - With bank address 1, it loads the fast output-enable option from address bit 0.
  - Any other bank address makes it a no-op.
  - Reset sets the latency to 3 and clears the option.
- R8: `rd_valid` is high for one cycle, starting at the CL-th clock edge after the edge that sampled an accepted read.
- R9: During an accepted write, `wr_byte_en` is the inverse of {dqm_hi,dqm_lo} with zero latency. At all other times it is 0.
- R10: `rd_drive` equals `rd_valid` ANDed with the inverse of the mask sampled L edges earlier. L is 1 when the CAS latency is 1 and the fast option is set, and 2 otherwise. Bit 0 is the low byte lane and bit 1 the high byte lane.
- R11: When CKE is sampled low while a bank is open, `pwr_state` becomes 1 (suspend). Commands are ignored and the read pipeline holds until CKE is sampled high. The pipeline then resumes one edge after the exit edge.
- R12: When CKE is sampled low with all banks idle, `pwr_state` becomes 3 (self-refresh) if a refresh command is present at that edge, and 2 (power-down) otherwise. Commands are ignored, and the first edge that samples CKE high returns the block to state 0.
- R13: Any rejected command sets `proto_err`, which stays set until reset. A rejected command reports code 0 and changes no bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | 2 | Bank address |
| addr | input | 12 | Address bus |
| dqm_lo | input | 1 | Low byte lane mask |
| dqm_hi | input | 1 | High byte lane mask |
| cmd_code | output | 3 | Executed command code |
| cmd_bank | output | 2 | Bank of last executed command |
| cmd_row | output | 12 | Address of last executed command |
| cmd_col | output | 9 | Column of last executed command |
| cmd_ap | output | 1 | Auto-precharge / all-banks bit of last command |
| bank_open | output | 4 | Open flag per bank |
| proto_err | output | 1 | Sticky protocol error |
| pwr_state | output | 2 | Clock-enable state |
| rd_valid | output | 1 | Read data valid |
| rd_drive | output | 2 | Per-lane read drive enable |
| wr_byte_en | output | 2 | Per-lane write enable |

## Verification
The checker watches several rules on every cycle:
- Once `proto_err` is set, it never clears.
- A deselected command leaves the bank flags untouched and reports a no-op.
- An all-banks precharge leaves every bank idle.
- No bank is open in power-down or self-refresh.
- `rd_valid` is frozen during suspend.
- Write enables appear only for selected commands while running.
- No read lane drives without `rd_valid`.

Some behaviour only the bench scenarios can show, because each depends on a count of edges against a programmed mode:
- The exact read latency for each CAS latency.
- The choice between a one-edge and a two-edge mask delay.
- The three-edge resume after a suspend.
- Which low-power state a given command selects.

// File: rtl/sdcf_pkg.sv
package sdcf_pkg;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_ACT  = 3'd1,
        CMD_RD   = 3'd2,
        CMD_WR   = 3'd3,
        CMD_PRE  = 3'd4,
        CMD_REF  = 3'd5,
        CMD_MRS  = 3'd6,
        CMD_EMRS = 3'd7
    } sdcf_cmd_e;

    typedef enum logic [1:0] {
        PS_RUN     = 2'd0,
        PS_SUSPEND = 2'd1,
        PS_PWRDN   = 2'd2,
        PS_SELFREF = 2'd3
    } sdcf_pwr_e;

    localparam int MAX_CL = 3;

endpackage

// File: rtl/sdcf_decode.sv
module sdcf_decode
    import sdcf_pkg::*;
#(
    parameter int BA_W = 2
) (
    input  logic            cs_n,
    input  logic            ras_n,
    input  logic            cas_n,
    input  logic            we_n,
    input  logic [BA_W-1:0] ba,
    output sdcf_cmd_e       cmd
);

    always_comb begin
        cmd = CMD_NOP;
        if (!cs_n) begin
            case ({ras_n, cas_n, we_n})
                3'b011: cmd = CMD_ACT;
                3'b101: cmd = CMD_RD;
                3'b100: cmd = CMD_WR;
                3'b010: cmd = CMD_PRE;
                3'b001: cmd = CMD_REF;
                3'b000: begin
                    if (ba == BA_W'(0))      cmd = CMD_MRS;
                    else if (ba == BA_W'(1)) cmd = CMD_EMRS;
                end
                default: cmd = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/sdcf_bank_track.sv
module sdcf_bank_track
    import sdcf_pkg::*;
#(
    parameter int BANKS = 4,
    localparam int BA_W = $clog2(BANKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  sdcf_cmd_e        cmd,
    input  logic [BA_W-1:0]  ba,
    input  logic             ap,
    output logic [BANKS-1:0] open_q,
    output logic             legal,
    output logic             err_q
);

    always_comb begin
        case (cmd)
            CMD_ACT:         legal = !open_q[ba];
            CMD_RD, CMD_WR:  legal = open_q[ba];
            default:         legal = 1'b1;
        endcase
    end

    for (genvar i = 0; i < BANKS; i++) begin : g_bank
        logic hit;
        assign hit = (ba == BA_W'(i));
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_q[i] <= 1'b0;
            end else if (adv && legal) begin
                if (cmd == CMD_ACT && hit)
                    open_q[i] <= 1'b1;
                else if ((cmd == CMD_RD || cmd == CMD_WR) && hit && ap)
                    open_q[i] <= 1'b0;
                else if (cmd == CMD_PRE && (ap || hit))
                    open_q[i] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)              err_q <= 1'b0;
        else if (adv && !legal)  err_q <= 1'b1;
    end

endmodule

// File: rtl/sdcf_power_fsm.sv
module sdcf_power_fsm
    import sdcf_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cke,
    input  logic      any_open,
    input  sdcf_cmd_e cmd,
    output sdcf_pwr_e state,
    output logic      adv
);

    sdcf_pwr_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PS_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_RUN: begin
                if (!cke) begin
                    if (any_open)            state_d = PS_SUSPEND;
                    else if (cmd == CMD_REF) state_d = PS_SELFREF;
                    else                     state_d = PS_PWRDN;
                end
            end
            PS_SUSPEND, PS_PWRDN, PS_SELFREF: begin
                if (cke) state_d = PS_RUN;
            end
        endcase
    end

    always_comb begin
        adv   = 1'b0;
        state = state_q;
        unique case (state_q)
            PS_RUN:                           adv = cke;
            PS_SUSPEND, PS_PWRDN, PS_SELFREF: adv = 1'b0;
        endcase
    end

endmodule

// File: rtl/sdcf_dqm_timing.sv
module sdcf_dqm_timing
    import sdcf_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             rd_issue,
    input  logic [1:0]       cas_lat,
    input  logic             fast_oe,
    input  logic [LANES-1:0] dqm,
    output logic             rd_valid,
    output logic [LANES-1:0] rd_drive
);

    localparam int OE_LAT = 2;

    logic [MAX_CL:0]    rpipe;
    logic [LANES-1:0]   mpipe [OE_LAT+1];
    logic [LANES-1:0]   mask_sel;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rpipe <= '0;
            for (int s = 0; s <= OE_LAT; s++) mpipe[s] <= '0;
        end else if (adv) begin
            rpipe    <= {rpipe[MAX_CL-1:0], rd_issue};
            mpipe[0] <= dqm;
            for (int s = 1; s <= OE_LAT; s++) mpipe[s] <= mpipe[s-1];
        end
    end

    assign rd_valid = rpipe[cas_lat];
    assign mask_sel = (cas_lat == 2'd1 && fast_oe) ? mpipe[1] : mpipe[OE_LAT];
    assign rd_drive = {LANES{rd_valid}} & ~mask_sel;

endmodule

// File: rtl/sdram_cmd_front.sv
module sdram_cmd_front
    import sdcf_pkg::*;
#(
    parameter int ROW_W = 12,
    parameter int BANKS = 4,
    parameter bit X16   = 1'b1,
    localparam int BA_W  = $clog2(BANKS),
    localparam int COL_W = 9,
    localparam int LANES = 2,
    localparam int AP_BIT = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke,
    input  logic             cs_n,
    input  logic             ras_n,
    input  logic             cas_n,
    input  logic             we_n,
    input  logic [BA_W-1:0]  ba,
    input  logic [ROW_W-1:0] addr,
    input  logic             dqm_lo,
    input  logic             dqm_hi,
    output logic [2:0]       cmd_code,
    output logic [BA_W-1:0]  cmd_bank,
    output logic [ROW_W-1:0] cmd_row,
    output logic [COL_W-1:0] cmd_col,
    output logic             cmd_ap,
    output logic [BANKS-1:0] bank_open,
    output logic             proto_err,
    output logic [1:0]       pwr_state,
    output logic             rd_valid,
    output logic [LANES-1:0] rd_drive,
    output logic [LANES-1:0] wr_byte_en
);

    sdcf_cmd_e        raw_cmd;
    sdcf_pwr_e        pstate;
    logic             adv;
    logic             legal;
    logic             take;
    logic [1:0]       cl_q;
    logic             fast_q;
    logic [LANES-1:0] lane_mask;
    logic [COL_W-1:0] col_d;

    sdcf_decode #(.BA_W(BA_W)) i_decode (
        .cs_n (cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba   (ba),   .cmd  (raw_cmd)
    );

    sdcf_power_fsm i_power (
        .clk     (clk),
        .rst_n   (rst_n),
        .cke     (cke),
        .any_open(|bank_open),
        .cmd     (raw_cmd),
        .state   (pstate),
        .adv     (adv)
    );

    sdcf_bank_track #(.BANKS(BANKS)) i_banks (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (adv),
        .cmd   (raw_cmd),
        .ba    (ba),
        .ap    (addr[AP_BIT]),
        .open_q(bank_open),
        .legal (legal),
        .err_q (proto_err)
    );

    assign take      = adv && legal;
    assign pwr_state = pstate;

    if (X16) begin : g_x16
        assign lane_mask = {dqm_hi, dqm_lo};
        assign col_d     = {1'b0, addr[7:0]};
    end else begin : g_x8
        assign lane_mask = {dqm_lo, dqm_lo};
        assign col_d     = addr[COL_W-1:0];
    end

    sdcf_dqm_timing #(.LANES(LANES)) i_dqm (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (adv),
        .rd_issue(take && raw_cmd == CMD_RD),
        .cas_lat (cl_q),
        .fast_oe (fast_q),
        .dqm     (lane_mask),
        .rd_valid(rd_valid),
        .rd_drive(rd_drive)
    );

    assign wr_byte_en = (take && raw_cmd == CMD_WR) ? ~lane_mask : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cl_q   <= 2'(MAX_CL);
            fast_q <= 1'b0;
        end else if (take) begin
            if (raw_cmd == CMD_MRS && addr[5:4] != 2'd0) cl_q <= addr[5:4];
            if (raw_cmd == CMD_EMRS)                     fast_q <= addr[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_code <= CMD_NOP;
            cmd_bank <= '0;
            cmd_row  <= '0;
            cmd_col  <= '0;
            cmd_ap   <= 1'b0;
        end else begin
            cmd_code <= take ? raw_cmd : CMD_NOP;
            if (take) begin
                cmd_bank <= ba;
                cmd_row  <= addr;
                cmd_col  <= col_d;
                cmd_ap   <= addr[AP_BIT];
            end
        end
    end

endmodule

// File: rtl/sdcf_checker.sv
module sdcf_checker #(
    parameter int ROW_W = 12,
    parameter int BANKS = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cke,
    input logic             cs_n,
    input logic             ras_n,
    input logic             cas_n,
    input logic             we_n,
    input logic [ROW_W-1:0] addr,
    input logic [2:0]       cmd_code,
    input logic [BANKS-1:0] bank_open,
    input logic             proto_err,
    input logic [1:0]       pwr_state,
    input logic             rd_valid,
    input logic [1:0]       rd_drive,
    input logic [1:0]       wr_byte_en
);

    p_err_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);

    p_deselect_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd0 && cke && cs_n) |=> (cmd_code == 3'd0 && $stable(bank_open)));

    p_precharge_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd0 && cke && !cs_n && !ras_n && cas_n && !we_n && addr[10])
        |=> (bank_open == '0));

    p_lowpower_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd2 || pwr_state == 2'd3) |-> (bank_open == '0));

    p_suspend_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd1) |=> $stable(rd_valid));

    p_write_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_byte_en != 2'b00) |-> (pwr_state == 2'd0 && cke && !cs_n));

    p_drive_needs_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_drive != 2'b00) |-> rd_valid);

endmodule

bind sdram_cmd_front sdcf_checker #(.ROW_W(ROW_W), .BANKS(BANKS)) i_sdcf_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cke       (cke),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .addr      (addr),
    .cmd_code  (cmd_code),
    .bank_open (bank_open),
    .proto_err (proto_err),
    .pwr_state (pwr_state),
    .rd_valid  (rd_valid),
    .rd_drive  (rd_drive),
    .wr_byte_en(wr_byte_en)
);

// File: tb/test_sdram_cmd_front.sv
module test_sdram_cmd_front;

    localparam int CLK_PERIOD = 10;

    localparam logic [3:0] C_ACT = 4'b0011;
    localparam logic [3:0] C_RD  = 4'b0101;
    localparam logic [3:0] C_WR  = 4'b0100;
    localparam logic [3:0] C_PRE = 4'b0010;
    localparam logic [3:0] C_REF = 4'b0001;
    localparam logic [3:0] C_MOD = 4'b0000;
    localparam logic [3:0] C_NOP = 4'b0111;

    // fields: cmd[25:22] ba[21:20] addr[19:8] code[7:5] open[4:1] err[0]
    localparam int NVEC = 14;
    localparam logic [25:0] VEC [NVEC] = '{
        {4'b0011, 2'd1, 12'h123, 3'd1, 4'b0010, 1'b0},
        {4'b0011, 2'd3, 12'h0AB, 3'd1, 4'b1010, 1'b0},
        {4'b0111, 2'd0, 12'h000, 3'd0, 4'b1010, 1'b0},
        {4'b1011, 2'd0, 12'h055, 3'd0, 4'b1010, 1'b0},
        {4'b0101, 2'd1, 12'h045, 3'd2, 4'b1010, 1'b0},
        {4'b0100, 2'd3, 12'h412, 3'd3, 4'b0010, 1'b0},
        {4'b0010, 2'd1, 12'h000, 3'd4, 4'b0000, 1'b0},
        {4'b0011, 2'd0, 12'h001, 3'd1, 4'b0001, 1'b0},
        {4'b0011, 2'd2, 12'h002, 3'd1, 4'b0101, 1'b0},
        {4'b0010, 2'd0, 12'h400, 3'd4, 4'b0000, 1'b0},
        {4'b0101, 2'd2, 12'h010, 3'd0, 4'b0000, 1'b1},
        {4'b0011, 2'd0, 12'h003, 3'd1, 4'b0001, 1'b1},
        {4'b0011, 2'd0, 12'h004, 3'd0, 4'b0001, 1'b1},
        {4'b0100, 2'd0, 12'h400, 3'd3, 4'b0000, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n, cke, cs_n, ras_n, cas_n, we_n, dqm_lo, dqm_hi;
    logic [1:0]  ba;
    logic [11:0] addr;
    logic [2:0]  cmd_code;
    logic [1:0]  cmd_bank;
    logic [11:0] cmd_row;
    logic [8:0]  cmd_col;
    logic        cmd_ap, proto_err, rd_valid;
    logic [3:0]  bank_open;
    logic [1:0]  pwr_state, rd_drive, wr_byte_en;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_cmd_front i_sdram_cmd_front (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
        .dqm_lo(dqm_lo), .dqm_hi(dqm_hi),
        .cmd_code(cmd_code), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
        .cmd_col(cmd_col), .cmd_ap(cmd_ap), .bank_open(bank_open),
        .proto_err(proto_err), .pwr_state(pwr_state), .rd_valid(rd_valid),
        .rd_drive(rd_drive), .wr_byte_en(wr_byte_en)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] c, input logic [1:0] b, input logic [11:0] a);
        {cs_n, ras_n, cas_n, we_n} = c;
        ba   = b;
        addr = a;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cke = 1'b1;
        {dqm_hi, dqm_lo} = 2'b00;
        drive(C_NOP, 2'd0, 12'h000);
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    task automatic read_latency(input logic [1:0] b, output int lat);
        drive(C_RD, b, 12'h000);
        tick();
        drive(C_NOP, 2'd0, 12'h000);
        lat = 0;
        for (int k = 1; k <= 6; k++) begin
            tick();
            if (rd_valid && lat == 0) lat = k;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        int lat;
        @(negedge clk);
        do_reset();

        // reset state (R1, R12, R13, R8)
        check("R1 reset cmd_code", cmd_code, 0);
        check("R3 reset bank_open", bank_open, 0);
        check("R13 reset proto_err", proto_err, 0);
        check("R12 reset pwr_state", pwr_state, 0);
        check("R8 reset rd_valid", rd_valid, 0);
        check("R9 reset wr_byte_en", wr_byte_en, 0);

        // vector table: R1 R2 R3 R4 R5 R6 R13
        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][25:22], VEC[i][21:20], VEC[i][19:8]);
            tick();
            check($sformatf("R1 R2 R4 vec %0d code", i), cmd_code, VEC[i][7:5]);
            check($sformatf("R3 R5 R6 vec %0d banks", i), bank_open, VEC[i][4:1]);
            check($sformatf("R13 vec %0d err", i), proto_err, VEC[i][0]);
        end

        // R13: only reset clears the flag
        do_reset();
        check("R13 err cleared by reset", proto_err, 0);

        // R1 / R4 address reporting
        drive(C_ACT, 2'd2, 12'hABC);
        tick();
        check("R1 activate row", cmd_row, 12'hABC);
        check("R1 activate bank", cmd_bank, 2);
        drive(C_RD, 2'd2, 12'h1FF);
        tick();
        check("R4 read column x16", cmd_col, 9'h0FF);
        check("R4 read no autoprecharge", cmd_ap, 0);
        check("R4 read code", cmd_code, 2);
        drive(C_NOP, 2'd0, 12'h000);
        repeat (4) tick();

        // R8 / R7 CAS latency
        read_latency(2'd2, lat);
        check("R8 latency reset CL3", lat, 3);
        drive(C_MOD, 2'd0, 12'h020);
        tick();
        read_latency(2'd2, lat);
        check("R8 latency CL2", lat, 2);
        drive(C_MOD, 2'd0, 12'h000);
        tick();
        read_latency(2'd2, lat);
        check("R7 zero field keeps CL", lat, 2);
        drive(C_MOD, 2'd0, 12'h010);
        tick();
        read_latency(2'd2, lat);
        check("R8 latency CL1", lat, 1);

        // R10 fast mask timing with CL1
        drive(C_MOD, 2'd1, 12'h001);
        tick();
        {dqm_hi, dqm_lo} = 2'b10;
        drive(C_RD, 2'd2, 12'h000);
        tick();
        {dqm_hi, dqm_lo} = 2'b00;
        drive(C_NOP, 2'd0, 12'h000);
        tick();
        check("R10 fast valid", rd_valid, 1);
        check("R10 fast one-edge mask", rd_drive, 2'b01);
        drive(C_MOD, 2'd1, 12'h000);
        tick();
        {dqm_hi, dqm_lo} = 2'b10;
        drive(C_RD, 2'd2, 12'h000);
        tick();
        {dqm_hi, dqm_lo} = 2'b00;
        drive(C_NOP, 2'd0, 12'h000);
        tick();
        check("R10 slow two-edge mask CL1", rd_drive, 2'b11);

        // R10 two-edge mask with CL3
        drive(C_MOD, 2'd0, 12'h030);
        tick();
        drive(C_RD, 2'd2, 12'h000);
        tick();
        drive(C_NOP, 2'd0, 12'h000);
        {dqm_hi, dqm_lo} = 2'b01;
        tick();
        {dqm_hi, dqm_lo} = 2'b00;
        tick();
        tick();
        check("R10 CL3 valid", rd_valid, 1);
        check("R10 CL3 low lane masked", rd_drive, 2'b10);

        // R9 write byte enables, zero latency
        {dqm_hi, dqm_lo} = 2'b01;
        drive(C_WR, 2'd2, 12'h000);
        #1;
        check("R9 write low lane masked", wr_byte_en, 2'b10);
        drive({1'b1, C_WR[2:0]}, 2'd2, 12'h000);
        #1;
        check("R9 deselected write no enable", wr_byte_en, 2'b00);
        {dqm_hi, dqm_lo} = 2'b00;
        drive(C_NOP, 2'd0, 12'h000);
        tick();

        // R11 clock suspend
        do_reset();
        drive(C_ACT, 2'd0, 12'h000);
        tick();
        drive(C_RD, 2'd0, 12'h000);
        tick();
        cke = 1'b0;
        drive(C_NOP, 2'd0, 12'h000);
        tick();
        check("R11 enter suspend", pwr_state, 1);
        drive(C_ACT, 2'd1, 12'h000);
        tick();
        tick();
        check("R11 command ignored in suspend", bank_open, 4'b0001);
        check("R11 read frozen", rd_valid, 0);
        cke = 1'b1;
        drive(C_NOP, 2'd0, 12'h000);
        tick();
        check("R11 exit suspend", pwr_state, 0);
        tick();
        tick();
        check("R11 read not yet", rd_valid, 0);
        tick();
        check("R11 read resumes", rd_valid, 1);

        // R12 power-down and self-refresh
        do_reset();
        cke = 1'b0;
        drive(C_NOP, 2'd0, 12'h000);
        tick();
        check("R12 power-down entry", pwr_state, 2);
        drive(C_ACT, 2'd2, 12'h000);
        tick();
        check("R12 command ignored in power-down", bank_open, 0);
        cke = 1'b1;
        drive(C_NOP, 2'd0, 12'h000);
        tick();
        check("R12 power-down exit", pwr_state, 0);
        cke = 1'b0;
        drive(C_REF, 2'd0, 12'h000);
        tick();
        check("R12 self-refresh entry", pwr_state, 3);
        cke = 1'b1;
        drive(C_NOP, 2'd0, 12'h000);
        tick();
        check("R12 self-refresh exit", pwr_state, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule